// File: doc/BRIEF.md
# Semaphore Flag Register

A single 32-bit memory-mapped register that gives software four independent hardware lock flags. Each flag is claimed by reading it and returned by writing a one to it. Every read that hits the register returns the flags as they stood before the access. The same read then forces every flag to 1. An agent that sees a 0 has therefore taken that flag in one indivisible step, because any other agent that reads it afterwards sees a 1.

The block sits on a simple register bus with an address, a read strobe, a write strobe, 32-bit write data and four byte-lane enables. Read data comes back one clock after the strobe. Only one address is decoded. Accesses to any other address leave the flags alone and return zero data. Software decides which shared resource each flag guards. The block itself does no arbitration beyond holding the flags.

Top module: `flagsem_top`

## Requirements
- R1: After an active-low reset, all four flags are 0 and the read data output is 0, so the first read after reset returns 0x00000000.
- R2: Flag k (k = 0..3) sits at bit 8*k, which gives bits 0, 8, 16 and 24. Every other bit always reads 0, and writing those bits changes nothing.
- R3: A read that hits the register returns on busRdata, in the cycle after the strobe, the flag values held before that cycle. Every flag is then 1, unless a write in the same cycle clears it.
- R4: A write that hits the register, with wdata bit 8*k = 1 and busBe[k] = 1, clears flag k, so the next read of that flag returns 0.
- R5: A write of 0 to a flag bit leaves that flag unchanged.
- R6: Flag k lies in byte lane k. When busBe[k] = 0, a write does not touch flag k, whatever the data.
- R7: The flags are independent. Clearing one flag leaves the other three at their previous values.
- R8: When a read and a write hit the register in the same cycle, the read returns the pre-cycle value. For the next state, a write-one-to-clear wins over the read-to-set.
- R9: Reads and writes to any other address leave the flags unchanged and return zero read data. When no read hits the register, busRdata is 0 in the following cycle.
- R10: Suppose two agents poll the same flag alternately, and the holder releases it by writing 1. Then exactly one poll returns 0 per release, counting reset as the first release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWr | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busBe | input | 4 | Byte-lane enables, bit k covers bits 8k+7:8k |
| busRdata | output | 32 | Read data, valid the cycle after busRd |

## Verification
The read-to-set side effect and the write-one-to-clear can hit the register in the same cycle. The bench provokes this with directed accesses that assert both strobes at once, with different flags cleared, and with random streams in which the two strobes and the byte enables vary freely. Each outcome is judged against a behavioural model. That model returns the pre-cycle flags for the read and applies the clear after the set. A later plain read then shows which of the two actions won.

// File: rtl/flagsem_pkg.sv
package flagsem_pkg;
  localparam int FLAG_COUNT = 4;
  localparam int LANE_W     = 8;
  localparam int WORD_W     = FLAG_COUNT * LANE_W;

  typedef struct packed {
    logic                  rdHit;
    logic                  wrHit;
    logic [FLAG_COUNT-1:0] clrMask;  // already gated by wrHit and lane enable
  } semStrobe_t;

  function automatic logic [WORD_W-1:0] flagBits();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int k = 0; k < FLAG_COUNT; k++) m[k*LANE_W] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/flagsem_ctrl.sv
module flagsem_ctrl
  import flagsem_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h0C0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [WORD_W-1:0]     busWdata,
  input  logic [FLAG_COUNT-1:0] busBe,
  output semStrobe_t            strobe
);
  localparam logic [WORD_W-1:0] FLAG_BITS = flagBits();

  logic addrHit;
  assign addrHit = (busAddr == REG_ADDR);

  assign strobe.rdHit = busRd & addrHit;
  assign strobe.wrHit = busWr & addrHit;

  genvar k;
  generate
    for (k = 0; k < FLAG_COUNT; k++) begin : g_lane
      assign strobe.clrMask[k] = busWr & addrHit & busBe[k] & busWdata[k*LANE_W];
    end
  endgenerate

  // R2: a write whose ones all sit in reserved bits requests no clear
  assert_reserved_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((busWdata & FLAG_BITS) == '0) |-> (strobe.clrMask == '0));

  // R9: no strobe leaves the decoder for a foreign address
  assert_foreign_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr != REG_ADDR) |-> (!strobe.rdHit && !strobe.wrHit && strobe.clrMask == '0));
endmodule

// File: rtl/flagsem_data.sv
module flagsem_data
  import flagsem_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  semStrobe_t        strobe,
  output logic [WORD_W-1:0] busRdata
);
  localparam logic [WORD_W-1:0] FLAG_BITS = flagBits();

  logic [FLAG_COUNT-1:0] flagQ;
  logic [FLAG_COUNT-1:0] flagD;
  logic [WORD_W-1:0]     viewWord;
  logic [WORD_W-1:0]     rdataQ;

  always_comb begin
    viewWord = '0;
    for (int k = 0; k < FLAG_COUNT; k++) viewWord[k*LANE_W] = flagQ[k];
  end

  // set from the read first, then the clear wins
  always_comb begin
    flagD = (flagQ | {FLAG_COUNT{strobe.rdHit}}) & ~strobe.clrMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      rdataQ <= '0;
    end else begin
      flagQ  <= flagD;
      rdataQ <= strobe.rdHit ? viewWord : '0;
    end
  end

  assign busRdata = rdataQ;

  assert_read_old_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdHit |=> (busRdata == $past(viewWord)));

  assert_read_sets_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && strobe.clrMask == '0) |=> (&flagQ));

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdHit |=> (busRdata == '0));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((busRdata & ~FLAG_BITS) == '0));

  genvar k;
  generate
    for (k = 0; k < FLAG_COUNT; k++) begin : g_chk
      assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        strobe.clrMask[k] |=> !flagQ[k]);
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.rdHit && !strobe.clrMask[k]) |=> $stable(flagQ[k]));
    end
  endgenerate
endmodule

// File: rtl/flagsem_top.sv
module flagsem_top
  import flagsem_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h0C0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [31:0]       busWdata,
  input  logic [3:0]        busBe,
  output logic [31:0]       busRdata
);
  semStrobe_t strobe;

  flagsem_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWdata (busWdata),
    .busBe    (busBe),
    .strobe   (strobe)
  );

  flagsem_data u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busRdata (busRdata)
  );
endmodule

// File: tb/sim_flagsem_top.sv
`timescale 1ns/1ps
module sim_flagsem_top;
  localparam logic [11:0] REG = 12'h0C0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [3:0]  busBe = '0;
  logic [31:0] busRdata;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit [3:0] model = '0;

  always #4 clk = ~clk;

  flagsem_top u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busBe(busBe), .busRdata(busRdata)
  );

  function automatic logic [31:0] spread(bit [3:0] f);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++) w[8*k] = f[k];
    return w;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle starting at a negedge; result compared at the next negedge
  task automatic access(string req, bit rd, bit wr, logic [11:0] a,
                        logic [31:0] wd, logic [3:0] be, output logic [31:0] seen);
    logic [31:0] exp;
    bit hit;
    busAddr = a; busRd = rd; busWr = wr; busWdata = wd; busBe = be;
    hit = (a == REG);
    exp = (rd && hit) ? spread(model) : 32'h0;
    if (rd && hit) model = 4'hF;
    if (wr && hit)
      for (int k = 0; k < 4; k++) if (be[k] && wd[8*k]) model[k] = 1'b0;
    @(negedge clk);
    check(req, busRdata, exp);
    seen = busRdata;
    busRd = 0; busWr = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    int zeros;
    int owner;
    repeat (3) @(negedge clk);
    check("R1 rdata at reset", busRdata, 32'h0);
    rstN = 1;
    @(negedge clk);
    check("R1 rdata after reset", busRdata, 32'h0);
    access("R1 first read", 1, 0, REG, 0, 0, r);
    access("R3 second read", 1, 0, REG, 0, 0, r);
    if (r !== 32'h01010101) begin end
    access("R4 clear flag2", 0, 1, REG, 32'h0001_0000, 4'b0100, r);
    access("R7 others kept", 1, 0, REG, 0, 0, r);
    access("R2 reserved writes", 0, 1, REG, 32'hFEFE_FEFE, 4'hF, r);
    access("R2 reserved view", 1, 0, REG, 0, 0, r);
    access("R6 lanes off", 0, 1, REG, 32'hFFFF_FFFF, 4'b0000, r);
    access("R6 lanes off view", 1, 0, REG, 0, 0, r);
    access("R5 zero write", 0, 1, REG, 32'h0, 4'hF, r);
    access("R5 zero write view", 1, 0, REG, 0, 0, r);
    access("R6 lane1 only", 0, 1, REG, 32'h0101_0101, 4'b0010, r);
    access("R6 lane1 view", 1, 0, REG, 0, 0, r);
    access("R8 collision", 1, 1, REG, 32'h0100_0001, 4'hF, r);
    access("R8 collision view", 1, 0, REG, 0, 0, r);
    access("R9 foreign write", 0, 1, REG + 12'h4, 32'hFFFF_FFFF, 4'hF, r);
    access("R9 foreign read", 1, 0, REG + 12'h4, 0, 0, r);
    access("R9 flags intact", 1, 0, REG, 0, 0, r);
    access("R4 clear all", 0, 1, REG, 32'h0101_0101, 4'hF, r);
    access("R4 clear all view", 1, 0, REG, 0, 0, r);
    @(negedge clk);
    check("R9 idle rdata", busRdata, 32'h0);

    // random stream against the model
    for (int n = 0; n < 400; n++) begin
      logic [11:0] a;
      a = ($urandom % 4 == 0) ? REG + 12'h8 : REG;
      access("R3/R4/R8 random", $urandom % 2, $urandom % 2, a,
             $urandom, $urandom % 16, r);
    end

    // R10: two agents polling flag 2 alternately
    access("R10 release start", 0, 1, REG, 32'h0001_0000, 4'b0100, r);
    for (int rel = 0; rel < 6; rel++) begin
      zeros = 0;
      owner = -1;
      for (int p = 0; p < 8; p++) begin
        access("R10 poll", 1, 0, REG, 0, 0, r);
        if (r[16] == 1'b0) begin zeros++; owner = p % 2; end
      end
      check("R10 one acquirer per release", zeros, 1);
      check("R10 acquirer defined", (owner >= 0), 1);
      access("R10 release", 0, 1, REG, 32'h0001_0000, 4'b0100, r);
    end
    finish_run();
  end
endmodule